// File: doc/BRIEF.md
# Texture Page Cache

This block is a 2 KB read cache that sits between a texture sampler and the 16-bit-word frame buffer that holds the textures. The sampler asks for one texel at a time by (u, v) inside the current texture page. The page is selected by a column group (`cfg_page_x`, 64 frame-buffer words per step) and a row band (`cfg_page_y`, 256 rows per step), together with a texel depth code. The cache returns the texel zero-extended to 16 bits.

Storage is 64 lines of sixteen 16-bit words. Each line maps directly from the texel coordinates. The tile this covers depends on depth: 64x64 texels at 4 bits, 64x32 at 8 bits and 32x32 at 16 bits. A miss holds the sampler off and fetches the sixteen words of the line in order through a request/response port to frame-buffer memory, then the held read is served.

Any change of depth or page invalidates every line at once. A fill that is under way when the configuration changes is allowed to drain but is never marked valid.

Top module: `texpage_cache`

## Requirements
- R1: With `cfg_bpp`=0 (4-bit), texel (u,v) is the nibble u[1:0] (nibble 0 = bits 3:0) of word column (page_x*64 + u/4) mod 1024, row page_y*256+v. It is returned in `rd_texel[3:0]` with the upper bits zero.
- R2: With `cfg_bpp`=1 (8-bit), texel (u,v) is byte u[0] (byte 0 = bits 7:0) of word column (page_x*64 + u/2) mod 1024 on the same row. It is returned in `rd_texel[7:0]` with the upper bits zero.
- R3: With `cfg_bpp`=2 or 3 (16-bit), texel (u,v) is the whole word at column (page_x*64 + u) mod 1024 on the same row.
- R4: A read whose line is present sees `rd_ready` high in the cycle it is presented. `rd_rvalid` with the texel follows exactly one cycle after acceptance, at every depth. `rd_rvalid` is never high otherwise.
- R5: A missing read keeps `rd_ready` low and issues exactly 16 word requests on the row of the texel. The first request is at column (page_x*64 + ((u>>s) & ~15)) mod 1024, where s = 2, 1, 0 for 4-, 8- and 16-bit texels. The held read is then accepted.
- R6: Line index is v[5:0] at 4 bits, {v[4:0],u[5]} at 8 bits and {v[4:0],u[4]} at 16 bits. Reads falling in an already filled line hit. A read with the same index but a different tag replaces the line and misses.
- R7: After reset no line is valid, `rd_rvalid` and `mem_req_valid` are low, and the first read misses.
- R8: A change of `cfg_bpp`, `cfg_page_x` or `cfg_page_y` invalidates every line. The next read misses and returns data of the new page.
- R9: A configuration change during a fill stops further requests and leaves that line invalid. The held read is then refilled and served from the new configuration.
- R10: No more than 16 word requests are outstanding, and no request is issued while `rd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bpp | input | 2 | Texel depth: 0 = 4-bit, 1 = 8-bit, 2/3 = 16-bit |
| cfg_page_x | input | 4 | Page column origin in units of 64 words |
| cfg_page_y | input | 1 | Page row origin in units of 256 rows |
| rd_valid | input | 1 | Texel read request, held until accepted |
| rd_u | input | 8 | Texel column inside the page |
| rd_v | input | 8 | Texel row inside the page |
| rd_ready | output | 1 | Read accepted this cycle when high with rd_valid |
| rd_rvalid | output | 1 | Texel data valid |
| rd_texel | output | 16 | Texel, zero-extended |
| mem_req_valid | output | 1 | Word request to frame-buffer memory |
| mem_req_x | output | 10 | Word column of the request |
| mem_req_y | output | 9 | Row of the request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Response word valid, in request order |
| mem_rsp_data | input | 16 | Response word |

## Verification
The bench targets the depth-dependent address split. A wrong nibble or byte order, or the wrong shift of u, returns the neighbour's texel. Line-boundary pairs are used: same index with a new tag, and just across the u[5] or u[4] split. A design that compared the index but not the tag would return another tile's data, and one with the wrong index bit would hit where it must miss.

Configuration changes are made both at idle and in the middle of a fill. A design that kept stale lines, or marked a cancelled fill valid, would serve texels of the previous page. The 16-bit page at the right-most column group checks that the column wraps.

// File: rtl/texcache_pkg.sv
package texcache_pkg;

    localparam int FB_XW      = 10;
    localparam int FB_YW      = 9;
    localparam int UVW        = 8;
    localparam int LINES      = 64;
    localparam int LINE_WORDS = 16;
    localparam int TEXW       = 16;
    localparam int IDXW       = $clog2(LINES);
    localparam int WOFFW      = $clog2(LINE_WORDS);
    localparam int ADDRW      = IDXW + WOFFW;
    localparam int TAGW       = 6;
    localparam int COLW       = UVW;
    localparam int PXW        = FB_XW - 6;
    localparam int PYW        = FB_YW - UVW;
    localparam int CNTW       = WOFFW + 1;

    typedef enum logic [1:0] {
        BPP4   = 2'd0,
        BPP8   = 2'd1,
        BPP16  = 2'd2,
        BPP16X = 2'd3
    } bpp_e;

    typedef struct packed {
        bpp_e           bpp;
        logic [PXW-1:0] px;
        logic [PYW-1:0] py;
    } tcfg_t;

    typedef struct packed {
        logic [IDXW-1:0]  idx;
        logic [TAGW-1:0]  tag;
        logic [WOFFW-1:0] woff;
        logic [1:0]       sub;
        logic [COLW-1:0]  col;
    } slot_t;

    function automatic slot_t locate(bpp_e b, logic [UVW-1:0] u, logic [UVW-1:0] v);
        slot_t s;
        s = '0;
        case (b)
            BPP4: begin
                s.idx  = v[5:0];
                s.tag  = {2'b00, u[7:6], v[7:6]};
                s.woff = u[5:2];
                s.sub  = u[1:0];
                s.col  = {2'b00, u[7:6], 4'b0000};
            end
            BPP8: begin
                s.idx  = {v[4:0], u[5]};
                s.tag  = {1'b0, u[7:6], v[7:5]};
                s.woff = u[4:1];
                s.sub  = {1'b0, u[0]};
                s.col  = {1'b0, u[7:5], 4'b0000};
            end
            default: begin
                s.idx  = {v[4:0], u[4]};
                s.tag  = {u[7:5], v[7:5]};
                s.woff = u[3:0];
                s.sub  = 2'b00;
                s.col  = {u[7:4], 4'b0000};
            end
        endcase
        return s;
    endfunction

    function automatic logic [TEXW-1:0] pick_texel(bpp_e b, logic [TEXW-1:0] w, logic [1:0] sub);
        logic [TEXW-1:0] sh;
        sh = w >> {sub, 2'b00};
        case (b)
            BPP4:    return {12'h000, sh[3:0]};
            BPP8:    return {8'h00, sub[0] ? w[15:8] : w[7:0]};
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/texcache_tags.sv
module texcache_tags
    import texcache_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [IDXW-1:0] look_idx,
    input  logic [TAGW-1:0] look_tag,
    output logic            hit,
    input  logic            inst_en,
    input  logic [IDXW-1:0] inst_idx,
    input  logic [TAGW-1:0] inst_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAGW-1:0]  tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid_q <= '0;
        end else if (inst_en) begin
            valid_q[inst_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_q[inst_idx] <= inst_tag;
        end
    end

    assign hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
endmodule

// File: rtl/texcache_fill.sv
module texcache_fill
    import texcache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDXW-1:0]  start_idx,
    input  logic [TAGW-1:0]  start_tag,
    input  logic [FB_XW-1:0] start_x,
    input  logic [FB_YW-1:0] start_y,
    input  logic             flush,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [FB_XW-1:0] mem_req_x,
    output logic [FB_YW-1:0] mem_req_y,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    output logic             wr_en,
    output logic [ADDRW-1:0] wr_addr,
    output logic             inst_en,
    output logic [IDXW-1:0]  inst_idx,
    output logic [TAGW-1:0]  inst_tag
);
    localparam logic [CNTW-1:0] FULL = CNTW'(LINE_WORDS);
    localparam logic [CNTW-1:0] LAST = CNTW'(LINE_WORDS - 1);

    logic             busy_q, killed_q;
    logic [CNTW-1:0]  req_cnt, rsp_cnt;
    logic [IDXW-1:0]  idx_q;
    logic [TAGW-1:0]  tag_q;
    logic [FB_XW-1:0] x_q;
    logic [FB_YW-1:0] y_q;
    logic             req_fire, last_rsp, drained, finish;

    assign busy          = busy_q;
    assign mem_req_valid = busy_q && !killed_q && (req_cnt < FULL);
    assign mem_req_x     = x_q + FB_XW'(req_cnt[WOFFW-1:0]);
    assign mem_req_y     = y_q;
    assign req_fire      = mem_req_valid && mem_req_ready;
    assign last_rsp      = busy_q && mem_rsp_valid && (rsp_cnt == LAST);
    assign drained       = busy_q && killed_q && (rsp_cnt == req_cnt);
    assign finish        = last_rsp || drained;

    assign wr_en    = busy_q && mem_rsp_valid;
    assign wr_addr  = {idx_q, rsp_cnt[WOFFW-1:0]};
    assign inst_en  = last_rsp && !killed_q && !flush;
    assign inst_idx = idx_q;
    assign inst_tag = tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            killed_q <= 1'b0;
            req_cnt  <= '0;
            rsp_cnt  <= '0;
            idx_q    <= '0;
            tag_q    <= '0;
            x_q      <= '0;
            y_q      <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q   <= 1'b1;
                killed_q <= 1'b0;
                req_cnt  <= '0;
                rsp_cnt  <= '0;
                idx_q    <= start_idx;
                tag_q    <= start_tag;
                x_q      <= start_x;
                y_q      <= start_y;
            end
        end else begin
            if (req_fire)      req_cnt  <= req_cnt + 1'b1;
            if (mem_rsp_valid) rsp_cnt  <= rsp_cnt + 1'b1;
            if (flush)         killed_q <= 1'b1;
            if (finish)        busy_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/texcache_store.sv
module texcache_store
    import texcache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [TEXW-1:0]  wr_data,
    input  logic             rd_en,
    input  logic [ADDRW-1:0] rd_addr,
    input  bpp_e             rd_bpp,
    input  logic [1:0]       rd_sub,
    output logic             rvalid,
    output logic [TEXW-1:0]  texel
);
    logic [TEXW-1:0] ram [LINES*LINE_WORDS];
    logic [TEXW-1:0] word_q;
    bpp_e            bpp_q;
    logic [1:0]      sub_q;
    logic            rvalid_q;

    always_ff @(posedge clk) begin
        if (wr_en) ram[wr_addr] <= wr_data;
        if (rd_en) begin
            word_q <= ram[rd_addr];
            bpp_q  <= rd_bpp;
            sub_q  <= rd_sub;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid_q <= 1'b0;
        else     rvalid_q <= rd_en;
    end

    assign rvalid = rvalid_q;
    assign texel  = pick_texel(bpp_q, word_q, sub_q);
endmodule

// File: rtl/texpage_cache.sv
module texpage_cache
    import texcache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_bpp,
    input  logic [PXW-1:0]   cfg_page_x,
    input  logic [PYW-1:0]   cfg_page_y,
    input  logic             rd_valid,
    input  logic [UVW-1:0]   rd_u,
    input  logic [UVW-1:0]   rd_v,
    output logic             rd_ready,
    output logic             rd_rvalid,
    output logic [TEXW-1:0]  rd_texel,
    output logic             mem_req_valid,
    output logic [FB_XW-1:0] mem_req_x,
    output logic [FB_YW-1:0] mem_req_y,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [TEXW-1:0]  mem_rsp_data
);
    tcfg_t            cfg_now, cfg_q;
    logic             cfg_chg;
    slot_t            slot;
    logic             hit, busy, accept, start;
    logic [FB_XW-1:0] line_x;
    logic [FB_YW-1:0] line_y;
    logic             wr_en, inst_en;
    logic [ADDRW-1:0] wr_addr;
    logic [IDXW-1:0]  inst_idx;
    logic [TAGW-1:0]  inst_tag;

    assign cfg_now = '{bpp: bpp_e'(cfg_bpp), px: cfg_page_x, py: cfg_page_y};
    assign cfg_chg = (cfg_now != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_now;
    end

    assign slot     = locate(cfg_now.bpp, rd_u, rd_v);
    assign line_x   = {cfg_page_x, 6'b000000} + FB_XW'(slot.col);
    assign line_y   = {cfg_page_y, rd_v};
    assign rd_ready = !busy && hit && !cfg_chg;
    assign accept   = rd_valid && rd_ready;
    assign start    = rd_valid && !busy && !hit && !cfg_chg;

    texcache_tags u_tags (
        .clk      (clk),
        .rst      (rst),
        .flush    (cfg_chg),
        .look_idx (slot.idx),
        .look_tag (slot.tag),
        .hit      (hit),
        .inst_en  (inst_en),
        .inst_idx (inst_idx),
        .inst_tag (inst_tag)
    );

    texcache_fill u_fill (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .start_idx     (slot.idx),
        .start_tag     (slot.tag),
        .start_x       (line_x),
        .start_y       (line_y),
        .flush         (cfg_chg),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_x     (mem_req_x),
        .mem_req_y     (mem_req_y),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .inst_en       (inst_en),
        .inst_idx      (inst_idx),
        .inst_tag      (inst_tag)
    );

    texcache_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (mem_rsp_data),
        .rd_en   (accept),
        .rd_addr ({slot.idx, slot.woff}),
        .rd_bpp  (cfg_now.bpp),
        .rd_sub  (slot.sub),
        .rvalid  (rd_rvalid),
        .texel   (rd_texel)
    );
endmodule

// File: rtl/texcache_chk.sv
module texcache_chk
    import texcache_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_bpp,
    input logic [PXW-1:0]   cfg_page_x,
    input logic [PYW-1:0]   cfg_page_y,
    input logic             rd_valid,
    input logic [UVW-1:0]   rd_u,
    input logic [UVW-1:0]   rd_v,
    input logic             rd_ready,
    input logic             rd_rvalid,
    input logic [TEXW-1:0]  rd_texel,
    input logic             mem_req_valid,
    input logic [FB_XW-1:0] mem_req_x,
    input logic [FB_YW-1:0] mem_req_y,
    input logic             mem_req_ready,
    input logic             mem_rsp_valid,
    input logic [TEXW-1:0]  mem_rsp_data
);
    logic [CNTW:0] outstanding;

    always_ff @(posedge clk) begin
        if (rst) outstanding <= '0;
        else outstanding <= outstanding
                          + (CNTW+1)'(mem_req_valid && mem_req_ready)
                          - (CNTW+1)'(mem_rsp_valid);
    end

    a_r4_rvalid_after_accept: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> rd_rvalid);

    a_r4_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_ready) |=> !rd_rvalid);

    a_r1_nibble_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && cfg_bpp == 2'd0) |=> (rd_texel[15:4] == 12'h000));

    a_r2_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && cfg_bpp == 2'd1) |=> (rd_texel[15:8] == 8'h00));

    a_r10_outstanding_bound: assert property (@(posedge clk) disable iff (rst)
        outstanding <= (CNTW+1)'(LINE_WORDS));

    a_r10_no_req_while_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rd_ready);

    a_r5_req_on_texel_row: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && $stable(cfg_page_y) && $stable(rd_v) && rd_valid)
            |-> (mem_req_y == {cfg_page_y, rd_v}));
endmodule

bind texpage_cache texcache_chk u_chk (.*);

// File: tb/tb_texpage_cache.sv
module tb_texpage_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_bpp = 2'd0;
    logic [3:0]  cfg_page_x = 4'd0;
    logic [0:0]  cfg_page_y = 1'b0;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_u = 8'd0, rd_v = 8'd0;
    logic        rd_ready, rd_rvalid;
    logic [15:0] rd_texel;
    logic        mem_req_valid;
    logic [9:0]  mem_req_x;
    logic [8:0]  mem_req_y;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = 16'h0;

    texpage_cache dut (.*);

    always #4 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic [15:0] rsp_q[$];
    int req_x_log[$];
    int req_y_log[$];
    logic [15:0] exp_q[$];
    string exp_tag[$];

    function automatic logic [15:0] fbw(int x, int y);
        logic [31:0] h;
        h = x * 32'd40503 + y * 32'd9973 + (x ^ y) * 32'd17 + 32'h5A3C;
        return h[15:0] ^ h[31:16];
    endfunction

    function automatic int shamt(int b);
        return (b == 0) ? 2 : (b == 1) ? 1 : 0;
    endfunction

    function automatic logic [15:0] exp_texel(int b, int px, int py, int u, int v);
        int x; logic [15:0] w;
        x = (px * 64 + (u >> shamt(b))) % 1024;
        w = fbw(x, py * 256 + v);
        if (b == 0) return (w >> (4 * (u % 4))) & 16'h000F;
        if (b == 1) return (u % 2) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
        return w;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // memory model: accepts requests, answers in order with gaps
    always @(posedge clk) begin
        cyc++;
        if (mem_req_valid && mem_req_ready) begin
            rsp_q.push_back(fbw(int'(mem_req_x), int'(mem_req_y)));
            req_x_log.push_back(int'(mem_req_x));
            req_y_log.push_back(int'(mem_req_y));
        end
        if (rst) mem_rsp_valid <= 1'b0;
        else if (rsp_q.size() > 0 && (cyc % 3) != 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rsp_q.pop_front();
        end else mem_rsp_valid <= 1'b0;
        mem_req_ready <= ((cyc % 4) != 2);
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rd_rvalid) begin
            if (exp_q.size() == 0) begin
                check(0, "R4", "rvalid with nothing expected", 1, 0);
            end else begin
                logic [15:0] e; string t;
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(rd_texel == e, t, "texel", int'(rd_texel), int'(e));
            end
        end
    end

    // driver: one read; returns cycles stalled and request-log position at start
    task automatic do_read(input int u, input int v, input string req,
                           output int stalls, output int log0,
                           input int chg_at = -1, input int new_px = 0);
        @(negedge clk);
        rd_valid = 1'b1; rd_u = 8'(u); rd_v = 8'(v);
        stalls = 0;
        log0 = req_x_log.size();
        forever begin
            #1;
            if (rd_ready) break;
            @(negedge clk);
            stalls++;
            if (stalls == chg_at) cfg_page_x = 4'(new_px);
        end
        exp_q.push_back(exp_texel(int'(cfg_bpp), int'(cfg_page_x), int'(cfg_page_y), u, v));
        exp_tag.push_back(req);
        @(posedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
        #1;
        check(rd_rvalid == 1'b1, "R4", "rvalid one cycle after accept", int'(rd_rvalid), 1);
    endtask

    task automatic expect_hit(int stalls, string req);
        check(stalls == 0, req, "hit expected, stall cycles", stalls, 0);
    endtask

    task automatic expect_miss(int stalls, int log0, int u, int v, string req);
        int nreq, ex, ey;
        check(stalls > 0, req, "miss expected, stall cycles", stalls, 1);
        nreq = req_x_log.size() - log0;
        check(nreq == 16, "R5", "word requests per fill", nreq, 16);
        ex = (int'(cfg_page_x) * 64 + ((u >> shamt(int'(cfg_bpp))) & ~15)) % 1024;
        ey = int'(cfg_page_y) * 256 + v;
        if (nreq > 0) begin
            check(req_x_log[log0] == ex, "R5", "first request column", req_x_log[log0], ex);
            check(req_y_log[log0] == ey, "R5", "request row", req_y_log[log0], ey);
        end
    endtask

    initial begin
        int s, l;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(rd_rvalid == 1'b0, "R7", "rvalid after reset", int'(rd_rvalid), 0);
        check(mem_req_valid == 1'b0, "R7", "mem_req_valid after reset", int'(mem_req_valid), 0);

        // 4-bit mode, page (0,0)
        do_read(0, 3, "R7", s, l);       expect_miss(s, l, 0, 3, "R7");
        do_read(1, 3, "R1", s, l);       expect_hit(s, "R1");
        do_read(2, 3, "R1", s, l);       expect_hit(s, "R1");
        do_read(3, 3, "R1", s, l);       expect_hit(s, "R1");
        do_read(40, 3, "R6", s, l);      expect_hit(s, "R6");
        do_read(64, 3, "R6", s, l);      expect_miss(s, l, 64, 3, "R6");
        do_read(0, 3, "R6", s, l);       expect_miss(s, l, 0, 3, "R6");
        do_read(0, 67, "R6", s, l);      expect_miss(s, l, 0, 67, "R6");

        // idle config change invalidates
        @(negedge clk); cfg_page_x = 4'd5;
        do_read(0, 67, "R8", s, l);      expect_miss(s, l, 0, 67, "R8");
        do_read(13, 67, "R8", s, l);     expect_hit(s, "R8");

        // 8-bit mode, page (2,1)
        @(negedge clk); cfg_bpp = 2'd1; cfg_page_x = 4'd2; cfg_page_y = 1'b1;
        do_read(131, 17, "R2", s, l);    expect_miss(s, l, 131, 17, "R2");
        do_read(130, 17, "R2", s, l);    expect_hit(s, "R2");
        do_read(158, 17, "R6", s, l);    expect_hit(s, "R6");
        do_read(160, 17, "R6", s, l);    expect_miss(s, l, 160, 17, "R6");

        // 16-bit mode, right-most page column group: wraps
        @(negedge clk); cfg_bpp = 2'd2; cfg_page_x = 4'd15; cfg_page_y = 1'b0;
        do_read(250, 255, "R3", s, l);   expect_miss(s, l, 250, 255, "R3");
        do_read(240, 255, "R3", s, l);   expect_hit(s, "R3");
        do_read(239, 255, "R6", s, l);   expect_miss(s, l, 239, 255, "R6");
        @(negedge clk); cfg_bpp = 2'd3;
        do_read(7, 9, "R3", s, l);       expect_miss(s, l, 7, 9, "R3");

        // config change in the middle of a fill
        @(negedge clk); cfg_bpp = 2'd0; cfg_page_x = 4'd1; cfg_page_y = 1'b0;
        do_read(200, 100, "R9", s, l, 5, 3);
        check(int'(cfg_page_x) == 3, "R9", "page moved during fill", int'(cfg_page_x), 3);
        do_read(200, 100, "R9", s, l);   expect_hit(s, "R9");
        do_read(201, 100, "R9", s, l);   expect_hit(s, "R9");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4", "pending expected texels", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule